// File: doc/BRIEF.md
# Conditional Branch and Program Counter Unit

This unit owns the 8-bit program counter of a small processor and decides, every clock, which address is fetched next. In the normal case the counter steps forward by one and wraps around at the top of the 256-byte address space. An instruction decoder upstream may instead request a branch. It supplies a 3-bit condition code and a target address. The unit tests the selected status flag (zero, negative, carry or overflow) in the polarity that the code names. When the test passes, the target replaces the counter.

A stall input freezes the counter, so a pipeline hazard or a wait on memory can hold the fetch address without losing it. A one-cycle taken flag tells the fetch stage that the address it now sees is not the one that follows the previous address. This lets the fetch stage discard work it had prefetched. Reset is synchronous and returns the counter to address 0x00.

Top module: `branch_pc_unit`

## Requirements
- R1: When rst is high at a rising clock edge, pc becomes 0x00 and taken becomes 0 after that edge, whatever the other inputs are.
- R2: With rst and stall low and branchReq low, each rising edge sets pc to the previous pc plus one, modulo 256, so 0xFF is followed by 0x00. taken is 0 after that edge.
- R3: Condition code 0 (binary 000) is unconditional. With branchReq high and stall low, pc takes the value of target at the edge, regardless of the flags.
- R4: Condition code 1 branches when flagZ is 1. Condition code 2 branches when flagZ is 0.
- R5: Condition code 3 branches when flagC is 1. Condition code 4 branches when flagC is 0.
- R6: Condition code 5 branches when flagN is 1. Condition code 6 branches when flagN is 0. Condition code 7 branches when flagV is 1.
- R7: When branchReq is high but the selected condition is false, the request has no effect: pc advances by one exactly as in R2, and taken stays 0.
- R8: When stall is high and rst is low, pc keeps its value across the edge, even when a branch that would be taken is presented. taken is 0 after that edge.
- R9: taken is 1 for exactly the one cycle that follows an edge at which target was loaded into pc, and is 0 in every other cycle.
- R10: A countdown loop that closes with condition code 2 (branch when not zero) returns to its loop head once per nonzero count. It falls through to the next address on the pass where the count reaches zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | Freeze pc for this cycle, active high |
| branchReq | input | 1 | A branch instruction is being executed this cycle |
| condCode | input | 3 | Branch condition selector (see R3 to R6) |
| target | input | 8 | Branch destination address |
| flagZ | input | 1 | Zero flag |
| flagN | input | 1 | Negative flag |
| flagC | input | 1 | Carry flag |
| flagV | input | 1 | Overflow flag |
| pc | output | 8 | Current program counter |
| taken | output | 1 | High for one cycle after a branch target is loaded |

## Verification
The bench applies each condition code with its flag both set and clear. A unit with swapped polarity or a wrong flag selection would then jump where it should fall through, or the reverse. The wrap from 0xFF to 0x00 is driven directly; a counter that saturated or widened would stick at 0xFF. A stall combined with a branch that would be taken exposes a design that lets the branch priority override the freeze, or that raises taken during a hold. A countdown loop closed by the not-zero branch must run its exact iteration count and then exit. This catches an off-by-one on the fall-through address or a condition sampled one cycle late.

// File: rtl/pc_unit_pkg.sv
package pc_unit_pkg;

  // Status flags presented by the ALU
  typedef struct packed {
    logic z;
    logic n;
    logic c;
    logic v;
  } flags_t;

  // Strobes from control to datapath; neither set means hold
  typedef struct packed {
    logic loadTarget;
    logic advance;
  } pcStrobe_t;

  // Which flag a condition code looks at
  typedef enum logic [2:0] {
    SRC_ALWAYS = 3'd0,
    SRC_ZERO   = 3'd1,
    SRC_CARRY  = 3'd2,
    SRC_NEG    = 3'd3,
    SRC_OVF    = 3'd4,
    SRC_NEVER  = 3'd5
  } flagSrc_e;

  // Map a condition code onto its flag source
  function automatic flagSrc_e srcOf(input int code);
    case (code)
      0:       return SRC_ALWAYS;
      1, 2:    return SRC_ZERO;
      3, 4:    return SRC_CARRY;
      5, 6:    return SRC_NEG;
      7:       return SRC_OVF;
      default: return SRC_NEVER;
    endcase
  endfunction

  // Odd codes test for a set flag, even nonzero codes for a clear one
  function automatic logic wantsSet(input int code);
    return (code % 2) == 1;
  endfunction

  function automatic logic condMet(input int code, input flags_t f);
    logic sel;
    case (srcOf(code))
      SRC_ALWAYS: return 1'b1;
      SRC_ZERO:   sel = f.z;
      SRC_CARRY:  sel = f.c;
      SRC_NEG:    sel = f.n;
      SRC_OVF:    sel = f.v;
      default:    return 1'b0;
    endcase
    return sel == wantsSet(code);
  endfunction

endpackage

// File: rtl/branch_ctrl.sv
module branch_ctrl
  import pc_unit_pkg::*;
#(
  parameter int COND_W = 3
) (
  input  logic              stall,
  input  logic              branchReq,
  input  logic [COND_W-1:0] condCode,
  input  flags_t            flags,
  output pcStrobe_t         strobe
);

  localparam int NUM_COND = 2 ** COND_W;

  logic [NUM_COND-1:0] metVec;
  logic                condHit;

  // One evaluator per condition code; the code selects among them
  for (genvar i = 0; i < NUM_COND; i++) begin : g_cond
    assign metVec[i] = condMet(i, flags);
  end

  assign condHit = metVec[condCode];

  always_comb begin
    strobe = '0;
    if (!stall) begin
      if (branchReq && condHit) strobe.loadTarget = 1'b1;
      else                      strobe.advance    = 1'b1;
    end
  end

endmodule

// File: rtl/pc_datapath.sv
module pc_datapath
  import pc_unit_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  pcStrobe_t         strobe,
  input  logic [ADDR_W-1:0] target,
  output logic [ADDR_W-1:0] pcQ,
  output logic              takenQ
);

  localparam logic [ADDR_W-1:0] RESET_ADDR = '0;
  localparam logic [ADDR_W-1:0] STEP       = ADDR_W'(1);

  logic [ADDR_W-1:0] pcNext;

  always_comb begin
    pcNext = pcQ;
    if (strobe.loadTarget)   pcNext = target;
    else if (strobe.advance) pcNext = pcQ + STEP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pcQ    <= RESET_ADDR;
      takenQ <= 1'b0;
    end else begin
      pcQ    <= pcNext;
      takenQ <= strobe.loadTarget;
    end
  end

endmodule

// File: rtl/branch_pc_unit.sv
module branch_pc_unit
  import pc_unit_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int COND_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stall,
  input  logic              branchReq,
  input  logic [COND_W-1:0] condCode,
  input  logic [ADDR_W-1:0] target,
  input  logic              flagZ,
  input  logic              flagN,
  input  logic              flagC,
  input  logic              flagV,
  output logic [ADDR_W-1:0] pc,
  output logic              taken
);

  flags_t    flags;
  pcStrobe_t strobe;

  assign flags = '{z: flagZ, n: flagN, c: flagC, v: flagV};

  branch_ctrl #(.COND_W(COND_W)) u_ctrl (
    .stall    (stall),
    .branchReq(branchReq),
    .condCode (condCode),
    .flags    (flags),
    .strobe   (strobe)
  );

  pc_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk   (clk),
    .rst   (rst),
    .strobe(strobe),
    .target(target),
    .pcQ   (pc),
    .takenQ(taken)
  );

endmodule

// File: rtl/branch_pc_chk.sv
module branch_pc_chk #(
  parameter int ADDR_W = 8,
  parameter int COND_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              stall,
  input logic              branchReq,
  input logic [COND_W-1:0] condCode,
  input logic [ADDR_W-1:0] target,
  input logic              flagZ,
  input logic [ADDR_W-1:0] pc,
  input logic              taken
);

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pc == '0) && !taken);

  // R2
  seq_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (!stall && !branchReq) |=> (pc == ADDR_W'($past(pc) + 1'b1)) && !taken);

  // R3
  uncond_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!stall && branchReq && condCode == '0) |=> (pc == $past(target)) && taken);

  // R7
  false_cond_chk: assert property (@(posedge clk) disable iff (rst)
    (!stall && branchReq && condCode == COND_W'(1) && !flagZ)
      |=> (pc == ADDR_W'($past(pc) + 1'b1)) && !taken);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    stall |=> $stable(pc) && !taken);

  // R9
  taken_cause_chk: assert property (@(posedge clk) disable iff (rst)
    taken |-> $past(branchReq) && !$past(stall) && (pc == $past(target)));

endmodule

bind branch_pc_unit branch_pc_chk #(.ADDR_W(ADDR_W), .COND_W(COND_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .stall    (stall),
  .branchReq(branchReq),
  .condCode (condCode),
  .target   (target),
  .flagZ    (flagZ),
  .pc       (pc),
  .taken    (taken)
);

// File: tb/tb_branch_pc_unit.sv
module tb_branch_pc_unit;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       stall = 1'b0;
  logic       branchReq = 1'b0;
  logic [2:0] condCode = '0;
  logic [7:0] target = '0;
  logic       flagZ = 1'b0, flagN = 1'b0, flagC = 1'b0, flagV = 1'b0;
  logic [7:0] pc;
  logic       taken;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;

  logic [7:0] expPc = '0;
  logic       expTaken = 1'b0;

  branch_pc_unit dut (
    .clk(clk), .rst(rst), .stall(stall), .branchReq(branchReq),
    .condCode(condCode), .target(target),
    .flagZ(flagZ), .flagN(flagN), .flagC(flagC), .flagV(flagV),
    .pc(pc), .taken(taken)
  );

  always #10 clk = ~clk;

  // Condition truth from R3..R6
  function automatic bit condTrue(input logic [2:0] cc, input bit z, n, c, v);
    case (cc)
      3'd0: return 1'b1;
      3'd1: return z;
      3'd2: return !z;
      3'd3: return c;
      3'd4: return !c;
      3'd5: return n;
      3'd6: return !n;
      default: return v;
    endcase
  endfunction

  function automatic string reqOf(input bit r, s, b, input logic [2:0] cc, input bit hit);
    if (r) return "R1";
    if (s) return "R8";
    if (!b) return "R2";
    if (!hit) return "R7";
    case (cc)
      3'd0: return "R3";
      3'd1, 3'd2: return "R4";
      3'd3, 3'd4: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] gotPc, wantPc,
                       input logic gotT, wantT);
    nChecks++;
    if (gotPc !== wantPc || gotT !== wantT) begin
      nFails++;
      $display("FAIL %s: pc=%02h taken=%0b expected pc=%02h taken=%0b",
               req, gotPc, gotT, wantPc, wantT);
    end
  endtask

  // Drive one cycle at the falling edge, predict, check at next falling edge
  task automatic cycle(input bit r, s, b, input logic [2:0] cc, input logic [7:0] tgt,
                       input bit z, n, c, v, input string tag);
    bit hit;
    rst = r; stall = s; branchReq = b; condCode = cc; target = tgt;
    flagZ = z; flagN = n; flagC = c; flagV = v;
    hit = condTrue(cc, z, n, c, v);
    if (r)            begin expPc = 8'h00;     expTaken = 1'b0; end
    else if (s)       begin                    expTaken = 1'b0; end
    else if (b && hit) begin expPc = tgt;      expTaken = 1'b1; end
    else              begin expPc = expPc + 8'd1; expTaken = 1'b0; end
    @(posedge clk);
    @(negedge clk);
    check(tag.len() != 0 ? tag : reqOf(r, s, b, cc, hit), pc, expPc, taken, expTaken);
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    int iters;
    logic [7:0] cnt;
    void'($urandom(32'h5eed_1234));
    @(negedge clk);
    // R1: reset state, even with a taken branch presented
    cycle(1, 0, 1, 3'd0, 8'hAA, 0, 0, 0, 0, "R1");
    cycle(1, 0, 0, 3'd0, 8'h00, 0, 0, 0, 0, "R1");
    // R2: sequential steps
    for (int i = 0; i < 3; i++) cycle(0, 0, 0, 3'd0, 8'h55, 1, 1, 1, 1, "R2");
    // R3: unconditional, flags all clear
    cycle(0, 0, 1, 3'd0, 8'hFD, 0, 0, 0, 0, "R3");
    // R9: taken drops after one cycle; R2 wrap 0xFF -> 0x00
    cycle(0, 0, 0, 3'd0, 8'h00, 0, 0, 0, 0, "R9");
    cycle(0, 0, 0, 3'd0, 8'h00, 0, 0, 0, 0, "R2");
    cycle(0, 0, 0, 3'd0, 8'h00, 0, 0, 0, 0, "R2 wrap");
    // R4..R6 and R7: every code with its flag set and clear
    for (int cc = 1; cc < 8; cc++) begin
      for (int f = 0; f < 2; f++) begin
        bit z, n, c, v;
        z = (cc <= 2) ? f[0] : !f[0];
        c = (cc == 3 || cc == 4) ? f[0] : !f[0];
        n = (cc == 5 || cc == 6) ? f[0] : !f[0];
        v = (cc == 7) ? f[0] : !f[0];
        cycle(0, 0, 1, 3'(cc), 8'(8'h10 * cc + f), z, n, c, v, "");
      end
    end
    // R8: stall with a taken branch, then with no branch
    cycle(0, 1, 1, 3'd0, 8'h77, 0, 0, 0, 0, "R8");
    cycle(0, 1, 0, 3'd0, 8'h77, 0, 0, 0, 0, "R8");
    cycle(0, 0, 0, 3'd0, 8'h00, 0, 0, 0, 0, "R2");
    // R10: countdown loop head at 0x40, count 5, closing with code 2
    cycle(0, 0, 1, 3'd0, 8'h40, 0, 0, 0, 0, "R10");
    cnt = 8'd5;
    iters = 0;
    for (int guard = 0; guard < 20; guard++) begin
      cycle(0, 0, 0, 3'd0, 8'h00, 0, 0, 0, 0, "R10");      // body
      cnt = cnt - 8'd1;
      cycle(0, 0, 0, 3'd0, 8'h00, cnt == 0, 0, 0, 0, "R10"); // decrement
      iters++;
      cycle(0, 0, 1, 3'd2, 8'h40, cnt == 0, 0, 0, 0, "R10"); // branch back
      if (pc != 8'h40) break;
    end
    nChecks++;
    if (iters != 5 || pc != 8'h43) begin
      nFails++;
      $display("FAIL R10: iterations=%0d exitPc=%02h expected iterations=5 exitPc=43", iters, pc);
    end
    // Random mix
    for (int k = 0; k < 400; k++) begin
      logic [3:0] fl;
      fl = 4'($urandom);
      cycle(($urandom % 50) == 0, ($urandom % 6) == 0, ($urandom % 2) == 0,
            3'($urandom), 8'($urandom), fl[0], fl[1], fl[2], fl[3], "");
    end
    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule